// File: doc/BRIEF.md
# Flash Array Bus Access Controller

This block sits between a 32-bit system bus and an on-chip flash array. Each bus request is compared against a configurable address window. Requests that fall outside the window are left alone, so another decoder on the same bus can answer them. A claimed request has its size and alignment checked. A legal read returns one array word, and the bus sees a ready pulse one clock after the request. An illegal access gets an error pulse instead.

To save power, the array's sense amplifiers are switched on only when a read is accepted. They are switched off again after a fixed time. That time is converted to clock cycles from a clock-period parameter, and each new read starts it again. Read data is captured on the edge that accepts the read, so the captured data does not depend on how long the enable stays high.

Writes follow stricter rules than reads. Only aligned 32-bit writes are accepted. An accepted write is not programmed into the array. It is held for a later command sequence, in one of two places chosen by a key-access control bit: a pending address/data register when the bit is clear, or a key register when it is set.

The controller is a four-state machine:
- ST_IDLE waits for a request.
- ST_RD_ACK is the response cycle of a legal read.
- ST_WR_ACK is the response cycle of a legal write.
- ST_ERR is the response cycle of an illegal access.

Its transitions are:
- ST_IDLE goes to ST_RD_ACK on a claimed legal read.
- ST_IDLE goes to ST_WR_ACK on a claimed legal write.
- ST_IDLE goes to ST_ERR on a claimed illegal access.
- ST_IDLE stays in ST_IDLE when there is no request or the address is outside the window.
- Each response state always returns to ST_IDLE on the next clock.

Top module: `flash_bus_ctrl`

## Requirements
- R1: A request is claimed only when `bus_req` is high and `bus_addr` lies in [BASE, BASE+SIZE_BYTES-1]. An out-of-window request produces no ready, no error and no change to the pending or key registers.
- R2: Reads of any aligned size complete with `bus_ready` high in the cycle after the request. Sizes are encoded as 00 byte, 01 halfword and 10 word. `bus_rdata` then holds the array word at index (bus_addr-BASE)>>2. The window's last word is readable.
- R3: A misaligned access gives `bus_err` in the cycle after the request. A halfword needs bit 0 clear, and a word needs bits 1:0 clear. Size code 11 is also an error, and so is a word write with address bits 1:0 non-zero.
- R4: A byte or halfword write ends with `bus_err`, even when it is aligned. Only an aligned word write gets `bus_ready`.
- R5: `bus_ready` and `bus_err` are never high together, and each lasts exactly one cycle per transfer. A request presented during the response cycle is ignored.
- R6: `sa_en` rises in the cycle in which a legal read is presented. It stays high for SA_CYC = ceil(SA_PS/CLK_PS) cycles in total, which is 3 at the defaults, and then falls. A rejected read does not raise it.
- R7: A new accepted read restarts the `sa_en` interval from its own request cycle.
- R8: An accepted write with `key_acc` low stores the address in `pend_addr` and the data in `pend_data`, and sets `pend_valid`. A later accepted write overwrites them.
- R9: An accepted write with `key_acc` high stores the data in `key_data` and sets `key_valid`. The pending registers are left unchanged.
- R10: After reset, `bus_ready`, `bus_err`, `sa_en`, `pend_valid`, `key_valid` and `bus_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Transfer request |
| bus_addr | input | 32 | Byte address |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| bus_wdata | input | 32 | Write data |
| key_acc | input | 1 | Key-access control bit selecting the write destination |
| bus_rdata | output | 32 | Read data captured at acceptance |
| bus_ready | output | 1 | Transfer completed (one-cycle pulse) |
| bus_err | output | 1 | Transfer error (one-cycle pulse) |
| arr_idx | output | AW | Word index into the array |
| arr_rdata | input | 32 | Array word at `arr_idx` |
| sa_en | output | 1 | Sense-amplifier enable |
| pend_valid | output | 1 | Pending write held |
| pend_addr | output | 32 | Pending write address |
| pend_data | output | 32 | Pending write data |
| key_valid | output | 1 | Key write held |
| key_data | output | 32 | Key write data |

## Verification
A controller stuck in a response state shows at once: the next request gets no ready or error in the following cycle, or the pulse lasts two cycles. A wrong decode is visible one cycle after the request, as a ready where an error belongs, or a response to an address outside the window. A faulty timeout counter shows within SA_CYC cycles, as `sa_en` falling early, staying high, or ignoring a new read. A misrouted write shows on the pending or key outputs in the cycle after acceptance.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_ACK,
        ST_WR_ACK,
        ST_ERR
    } bus_state_e;

    typedef struct packed {
        logic claim;
        logic legal;
        logic is_rd;
    } decode_t;

endpackage

// File: rtl/flash_win_decode.sv
module flash_win_decode
    import flash_bus_pkg::*;
#(
    parameter logic [31:0] BASE       = 32'h0080_0000,
    parameter logic [31:0] SIZE_BYTES = 32'h0004_0000,
    parameter int          AW         = 16
) (
    input  logic          req,
    input  logic [31:0]   addr,
    input  logic          wr,
    input  logic [1:0]    size,
    output decode_t       dec,
    output logic [AW-1:0] word_idx
);

    localparam logic [31:0] LAST = BASE + SIZE_BYTES - 32'd1;

    logic        in_win;
    logic        aligned;
    logic [31:0] offset;
    xfer_size_e  sz;

    always_comb begin
        sz       = xfer_size_e'(size);
        in_win   = (addr >= BASE) && (addr <= LAST);
        offset   = addr - BASE;
        word_idx = offset[AW+1:2];
        unique case (sz)
            SZ_BYTE: aligned = 1'b1;
            SZ_HALF: aligned = (addr[0] == 1'b0);
            SZ_WORD: aligned = (addr[1:0] == 2'b00);
            default: aligned = 1'b0;
        endcase
        dec.claim = req && in_win;
        dec.is_rd = !wr;
        dec.legal = wr ? ((sz == SZ_WORD) && aligned) : aligned;
    end

endmodule

// File: rtl/flash_sa_timer.sv
module flash_sa_timer #(
    parameter int CLK_PS = 20000,
    parameter int SA_PS  = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic sa_en
);

    localparam int SA_RAW = (SA_PS + CLK_PS - 1) / CLK_PS;
    localparam int SA_CYC = (SA_RAW < 1) ? 1 : SA_RAW;
    localparam int CW     = (SA_CYC < 2) ? 1 : $clog2(SA_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(SA_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign sa_en = start || (cnt_q != '0);

endmodule

// File: rtl/flash_wr_latch.sv
module flash_wr_latch (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  logic        key_acc,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output logic        pend_valid,
    output logic [31:0] pend_addr,
    output logic [31:0] pend_data,
    output logic        key_valid,
    output logic [31:0] key_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
        end else if (accept && !key_acc) begin
            pend_valid <= 1'b1;
            pend_addr  <= addr;
            pend_data  <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_valid <= 1'b0;
            key_data  <= '0;
        end else if (accept && key_acc) begin
            key_valid <= 1'b1;
            key_data  <= wdata;
        end
    end

endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
    import flash_bus_pkg::*;
#(
    parameter logic [31:0] BASE       = 32'h0080_0000,
    parameter logic [31:0] SIZE_BYTES = 32'h0004_0000,
    parameter int          CLK_PS     = 20000,
    parameter int          SA_PS      = 50000,
    localparam int         AW         = $clog2(SIZE_BYTES / 4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic [31:0]   bus_addr,
    input  logic          bus_wr,
    input  logic [1:0]    bus_size,
    input  logic [31:0]   bus_wdata,
    input  logic          key_acc,
    output logic [31:0]   bus_rdata,
    output logic          bus_ready,
    output logic          bus_err,
    output logic [AW-1:0] arr_idx,
    input  logic [31:0]   arr_rdata,
    output logic          sa_en,
    output logic          pend_valid,
    output logic [31:0]   pend_addr,
    output logic [31:0]   pend_data,
    output logic          key_valid,
    output logic [31:0]   key_data
);

    bus_state_e  state_q, state_d;
    decode_t     dec;
    logic        idle;
    logic        rd_go;
    logic        wr_go;
    logic [31:0] rdata_q;

    flash_win_decode #(
        .BASE       (BASE),
        .SIZE_BYTES (SIZE_BYTES),
        .AW         (AW)
    ) u_dec (
        .req      (bus_req),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .size     (bus_size),
        .dec      (dec),
        .word_idx (arr_idx)
    );

    assign idle  = (state_q == ST_IDLE);
    assign rd_go = idle && dec.claim && dec.legal && dec.is_rd;
    assign wr_go = idle && dec.claim && dec.legal && !dec.is_rd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dec.claim) begin
                    if (!dec.legal)     state_d = ST_ERR;
                    else if (dec.is_rd) state_d = ST_RD_ACK;
                    else                state_d = ST_WR_ACK;
                end
            end
            ST_RD_ACK: state_d = ST_IDLE;
            ST_WR_ACK: state_d = ST_IDLE;
            ST_ERR:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        bus_ready = 1'b0;
        bus_err   = 1'b0;
        unique case (state_q)
            ST_RD_ACK: bus_ready = 1'b1;
            ST_WR_ACK: bus_ready = 1'b1;
            ST_ERR:    bus_err   = 1'b1;
            default: ;
        endcase
    end

    // read data captured on the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_go) rdata_q <= arr_rdata;
    end
    assign bus_rdata = rdata_q;

    flash_sa_timer #(
        .CLK_PS (CLK_PS),
        .SA_PS  (SA_PS)
    ) u_sa (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rd_go),
        .sa_en (sa_en)
    );

    flash_wr_latch u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (wr_go),
        .key_acc    (key_acc),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .pend_data  (pend_data),
        .key_valid  (key_valid),
        .key_data   (key_data)
    );

endmodule

// File: rtl/flash_bus_ctrl_chk.sv
module flash_bus_ctrl_chk #(
    parameter logic [31:0] BASE       = 32'h0080_0000,
    parameter logic [31:0] SIZE_BYTES = 32'h0004_0000,
    parameter int          CLK_PS     = 20000,
    parameter int          SA_PS      = 50000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic [31:0] bus_addr,
    input logic        bus_wr,
    input logic [1:0]  bus_size,
    input logic        key_acc,
    input logic        bus_ready,
    input logic        bus_err,
    input logic        sa_en,
    input logic        pend_valid
);

    localparam int          SA_RAW = (SA_PS + CLK_PS - 1) / CLK_PS;
    localparam int          SA_CYC = (SA_RAW < 1) ? 1 : SA_RAW;
    localparam logic [31:0] LAST   = BASE + SIZE_BYTES - 32'd1;

    logic       in_win;
    logic       rd_cand;
    logic [7:0] age_q;
    logic [7:0] age_now;

    assign in_win  = (bus_addr >= BASE) && (bus_addr <= LAST);
    assign rd_cand = bus_req && !bus_wr && in_win;
    assign age_now = rd_cand ? 8'd0 : age_q;

    // cycles since the last possible read start, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 age_q <= 8'hFF;
        else if (rd_cand)           age_q <= 8'd1;
        else if (age_q != 8'hFF)    age_q <= age_q + 8'd1;
    end

    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ready && bus_err));

    a_r5_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err);

    a_r1_claimed_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready || bus_err) |-> $past(bus_req && in_win));

    a_r4_word_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && $past(bus_wr)) |-> ($past(bus_size) == 2'b10 && $past(bus_addr[1:0]) == 2'b00));

    a_r8_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_valid) |-> $past(bus_req && bus_wr && !key_acc && in_win));

    a_r6_sa_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        sa_en |-> (int'(age_now) < SA_CYC));

endmodule

bind flash_bus_ctrl flash_bus_ctrl_chk #(
    .BASE       (BASE),
    .SIZE_BYTES (SIZE_BYTES),
    .CLK_PS     (CLK_PS),
    .SA_PS      (SA_PS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_size   (bus_size),
    .key_acc    (key_acc),
    .bus_ready  (bus_ready),
    .bus_err    (bus_err),
    .sa_en      (sa_en),
    .pend_valid (pend_valid)
);

// File: tb/flash_bus_ctrl_bench.sv
`timescale 1ns/1ps
module flash_bus_ctrl_bench;

    localparam logic [31:0] BASE = 32'h0080_0000;
    localparam int          AW   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic [31:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_size = 2'b00;
    logic [31:0]   bus_wdata = '0;
    logic          key_acc = 1'b0;
    logic [31:0]   bus_rdata;
    logic          bus_ready, bus_err;
    logic [AW-1:0] arr_idx;
    logic [31:0]   arr_rdata;
    logic          sa_en, pend_valid, key_valid;
    logic [31:0]   pend_addr, pend_data, key_data;

    always #10 clk = ~clk;

    // array model: word content is a function of its index
    assign arr_rdata = {arr_idx ^ 16'hA5C3, arr_idx};

    flash_bus_ctrl u_flash_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .key_acc(key_acc), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .bus_err(bus_err), .arr_idx(arr_idx), .arr_rdata(arr_rdata),
        .sa_en(sa_en), .pend_valid(pend_valid), .pend_addr(pend_addr),
        .pend_data(pend_data), .key_valid(key_valid), .key_data(key_data)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  size;
        logic        key;
        logic [1:0]  exp;   // 0 none, 1 ready, 2 error
        logic [31:0] addr;
        logic [31:0] wdata;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'b00, 1'b0, 2'd1, 32'h0080_0003, 32'h0},
        '{1'b0, 2'b01, 1'b0, 2'd1, 32'h0080_0006, 32'h0},
        '{1'b0, 2'b10, 1'b0, 2'd1, 32'h0080_0010, 32'h0},
        '{1'b0, 2'b01, 1'b0, 2'd2, 32'h0080_0005, 32'h0},
        '{1'b0, 2'b10, 1'b0, 2'd2, 32'h0080_0012, 32'h0},
        '{1'b0, 2'b11, 1'b0, 2'd2, 32'h0080_0010, 32'h0},
        '{1'b1, 2'b10, 1'b0, 2'd1, 32'h0080_0020, 32'hCAFE_0001},
        '{1'b1, 2'b00, 1'b0, 2'd2, 32'h0080_0024, 32'h1111_1111},
        '{1'b1, 2'b01, 1'b0, 2'd2, 32'h0080_0026, 32'h2222_2222},
        '{1'b1, 2'b10, 1'b0, 2'd2, 32'h0080_0022, 32'h3333_3333},
        '{1'b1, 2'b10, 1'b1, 2'd1, 32'h0080_0030, 32'h5EC0_0042},
        '{1'b0, 2'b10, 1'b0, 2'd1, 32'h0083_FFFC, 32'h0},
        '{1'b0, 2'b10, 1'b0, 2'd0, 32'h0084_0000, 32'h0},
        '{1'b1, 2'b10, 1'b0, 2'd0, 32'h007F_FFFC, 32'h4444_4444},
        '{1'b1, 2'b10, 1'b0, 2'd1, 32'h0080_0040, 32'hBEEF_0002}
    };

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    logic        m_pv = 1'b0, m_kv = 1'b0;
    logic [31:0] m_pa = '0, m_pd = '0, m_kd = '0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.exp == 2'd0) return "R1";
        if (v.exp == 2'd2) return (v.wr && v.size != 2'b10) ? "R4" : "R3";
        if (!v.wr)         return "R2";
        return v.key ? "R9" : "R8";
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] a);
        logic [31:0] off;
        logic [15:0] idx;
        off = a - BASE;
        idx = off[17:2];
        return {idx ^ 16'hA5C3, idx};
    endfunction

    task automatic drive(input logic wr, input logic [1:0] sz, input logic key,
                         input logic [31:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_wr = wr; bus_size = sz; key_acc = key;
        bus_addr = a; bus_wdata = d;
    endtask

    task automatic release_bus();
        bus_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10", "ready", {31'b0, bus_ready}, 32'd0);
        chk("R10", "err",   {31'b0, bus_err},   32'd0);
        chk("R10", "sa_en", {31'b0, sa_en},     32'd0);
        chk("R10", "pend_valid", {31'b0, pend_valid}, 32'd0);
        chk("R10", "key_valid",  {31'b0, key_valid},  32'd0);
        chk("R10", "rdata", bus_rdata, 32'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = VEC[i];
            t = tag_of(v);
            @(negedge clk);
            drive(v.wr, v.size, v.key, v.addr, v.wdata);
            @(negedge clk);
            chk(t, "ready", {31'b0, bus_ready}, {31'b0, v.exp == 2'd1});
            chk(t, "err",   {31'b0, bus_err},   {31'b0, v.exp == 2'd2});
            if (v.exp == 2'd1 && !v.wr) chk(t, "rdata", bus_rdata, word_at(v.addr));
            if (v.exp == 2'd1 && v.wr) begin
                if (v.key) begin m_kv = 1'b1; m_kd = v.wdata; end
                else begin m_pv = 1'b1; m_pa = v.addr; m_pd = v.wdata; end
            end
            release_bus();
            @(negedge clk);
            // R5 single-cycle response
            chk("R5", "ready low after pulse", {31'b0, bus_ready}, 32'd0);
            chk("R5", "err low after pulse",   {31'b0, bus_err},   32'd0);
            chk(t, "pend_valid", {31'b0, pend_valid}, {31'b0, m_pv});
            chk(t, "pend_addr",  pend_addr, m_pa);
            chk(t, "pend_data",  pend_data, m_pd);
            chk(t, "key_valid",  {31'b0, key_valid}, {31'b0, m_kv});
            chk(t, "key_data",   key_data, m_kd);
        end

        // R5: request changed during response cycle is ignored
        @(negedge clk);
        drive(1'b1, 2'b10, 1'b0, 32'h0080_0050, 32'h0000_AAAA);
        @(negedge clk);
        chk("R5", "write ack", {31'b0, bus_ready}, 32'd1);
        bus_wdata = 32'h0000_BBBB;
        bus_addr  = 32'h0080_0054;
        @(negedge clk);
        release_bus();
        chk("R5", "no ack for request in response cycle", {31'b0, bus_ready}, 32'd0);
        chk("R5", "pend_data kept", pend_data, 32'h0000_AAAA);
        chk("R5", "pend_addr kept", pend_addr, 32'h0080_0050);

        // R6: rejected read does not raise sa_en
        @(negedge clk);
        @(negedge clk);
        drive(1'b0, 2'b10, 1'b0, 32'h0080_0011, 32'h0);
        #1;
        chk("R6", "sa_en on misaligned read", {31'b0, sa_en}, 32'd0);
        @(negedge clk);
        release_bus();
        repeat (3) @(negedge clk);

        // R6: interval of SA_CYC = 3 cycles
        drive(1'b0, 2'b10, 1'b0, 32'h0080_0100, 32'h0);
        #1;
        chk("R6", "sa_en in request cycle", {31'b0, sa_en}, 32'd1);
        @(negedge clk);
        release_bus();
        chk("R6", "sa_en cycle 2", {31'b0, sa_en}, 32'd1);
        @(negedge clk);
        chk("R6", "sa_en cycle 3", {31'b0, sa_en}, 32'd1);
        @(negedge clk);
        chk("R6", "sa_en dropped", {31'b0, sa_en}, 32'd0);

        // R7: restart on a new read
        @(negedge clk);
        drive(1'b0, 2'b00, 1'b0, 32'h0080_0200, 32'h0);
        @(negedge clk);
        release_bus();
        @(negedge clk);
        drive(1'b0, 2'b01, 1'b0, 32'h0080_0302, 32'h0);
        @(negedge clk);
        release_bus();
        chk("R7", "rdata of second read", bus_rdata, word_at(32'h0080_0302));
        chk("R7", "sa_en held after restart", {31'b0, sa_en}, 32'd1);
        @(negedge clk);
        chk("R7", "sa_en still held", {31'b0, sa_en}, 32'd1);
        @(negedge clk);
        chk("R7", "sa_en dropped after restart", {31'b0, sa_en}, 32'd0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule